// File: doc/BRIEF.md
# Mixed-Length Instruction Boundary Decoder

This block takes a fetch window of eight 16-bit parcels each cycle and finds where every instruction in it begins and how long it is. Instructions are 16 or 32 bits long. A 32-bit instruction may start at any parcel. The two lowest bits of an instruction's first parcel decide its length, so the decoder links the parcels into a chain of boundaries across the whole window in one pass. It then registers up to six instruction slots, the number of slots filled, and the number of parcels the upstream buffer may drop.

A 32-bit instruction can start in the last parcel, so that its upper half lies in the next window. In that case the decoder keeps the lower half in a register. On the next accepted window it emits that instruction as slot 0, joined with parcel 0, and starts the chain at parcel 1. A downstream ready input stalls the block. A flush input drops the held half.

Top module: `insn_boundary_decoder`

## Requirements
- R1: A parcel that starts an instruction gives a 32-bit instruction (slot length bit 1) when its bits [1:0] are 2'b11. Any other value of those bits gives a 16-bit instruction (length bit 0). No other bit affects the length.
- R2: The long flag of a slot is set when the first parcel's bits [4:0] equal 5'b11111. Such an instruction is still handled as 32 bits.
- R3: Without a held half, the first instruction starts at parcel `start_off`, and each later slot starts at the parcel right after the previous instruction ends. Slot indices rise with slot number. `o_used` counts parcels from the chain's first parcel through the end of the last emitted or held instruction. The chain's first parcel is `start_off`, or parcel 0 when a held half is joined.
- R4: At most 6 slots are emitted per window, and `o_count` equals the number of valid slots. An all-16-bit window with `start_off`=0 gives 6 slots at parcels 0..5 and `o_used`=6.
- R5: An all-32-bit window with `start_off`=0 gives 4 slots at parcels 0,2,4,6 and `o_used`=8.
- R6: A 32-bit instruction reached at parcel 7 while fewer than 6 slots are filled is not emitted. Its parcel is counted in `o_used` and held. The next accepted window emits it as slot 0 with index 0, length 1 and `o_head_used`=1, and with `o_head` equal to the held parcel and its long flag taken from that parcel. That window's chain continues at parcel 1, and `start_off` is ignored for it.
- R7: While `ready` is low and `flush` is low, all outputs and the held half keep their values, and the input window is not taken.
- R8: `flush` (whatever the value of `ready`) clears the held half and sets `o_count`, `o_slot_vld`, `o_valid` and `o_head_used` to zero on the next edge.
- R9: With `ready` high and `win_valid` low, the next outputs show `o_valid`=0 and `o_count`=0, and a held half is kept for the next valid window.
- R10: After reset, `o_valid`, `o_count`, `o_slot_vld` and `o_head_used` are zero and no half is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop the held half and clear outputs |
| ready | input | 1 | Downstream can accept; low stalls the block |
| win_valid | input | 1 | Fetch window is valid |
| start_off | input | 3 | Parcel where the first instruction begins |
| window | input | 128 | Eight parcels, parcel i at bits [16i+15:16i] |
| o_valid | output | 1 | Registered window-valid |
| o_slot_vld | output | 6 | Slot valid bits |
| o_slot_idx | output | 18 | Per-slot parcel index, slot s at bits [3s+2:3s] |
| o_slot_len | output | 6 | Per-slot length bit, 1 = 32-bit |
| o_slot_long | output | 6 | Per-slot longer-than-32-bit encoding flag |
| o_head_used | output | 1 | Slot 0 is the joined straddling instruction |
| o_head | output | 16 | Lower half of the joined instruction |
| o_count | output | 3 | Number of valid slots |
| o_used | output | 4 | Parcels consumed |

## Verification
The hardest case to reach is a held half that must survive across other events. It has to stay in place through a stalled cycle or an idle cycle, then come out joined with the next valid window, or be dropped by a flush. A 32-bit start only lands on parcel 7 for certain pairs of offset and length mix, and the cap of 6 must not be reached first. The sweep steps through every offset with every 32/16 mask, so these landings happen many times in a row, often back to back. Directed sequences then set up a straddle on purpose, with `start_off`=2, and put a stall, an idle cycle or a flush between that window and the next.

// File: rtl/insn_boundary_decoder.sv
module insn_boundary_decoder #(
  parameter int NP  = 8,
  parameter int CAP = 6,
  parameter int PW  = 16,
  parameter int IW  = $clog2(NP),
  parameter int CW  = $clog2(CAP + 1),
  parameter int UW  = $clog2(NP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ready,
  input  logic              win_valid,
  input  logic [IW-1:0]     start_off,
  input  logic [NP*PW-1:0]  window,
  output logic              o_valid,
  output logic [CAP-1:0]    o_slot_vld,
  output logic [CAP*IW-1:0] o_slot_idx,
  output logic [CAP-1:0]    o_slot_len,
  output logic [CAP-1:0]    o_slot_long,
  output logic              o_head_used,
  output logic [PW-1:0]     o_head,
  output logic [CW-1:0]     o_count,
  output logic [UW-1:0]     o_used
);

  logic          pend_q;
  logic [PW-1:0] head_q;
  logic [NP-1:0] is32, islong;

  for (genvar g = 0; g < NP; g++) begin : g_len
    assign is32[g]   = window[g*PW +: 2] == 2'b11;
    assign islong[g] = window[g*PW +: 5] == 5'b11111;
  end

  logic [CAP-1:0]    d_vld, d_len, d_long;
  logic [CAP*IW-1:0] d_idx;
  logic [CW-1:0]     d_cnt;
  logic [UW-1:0]     d_used;
  logic              d_strad;

  always_comb begin
    int cnt, nxt, base;
    d_vld   = '0;
    d_len   = '0;
    d_long  = '0;
    d_idx   = '0;
    d_strad = 1'b0;
    cnt     = 0;
    base    = pend_q ? 0 : int'(start_off);
    nxt     = pend_q ? 1 : int'(start_off);
    if (pend_q) begin
      d_vld[0]  = 1'b1;
      d_len[0]  = 1'b1;
      d_long[0] = head_q[4:0] == 5'b11111;
      cnt       = 1;
    end
    for (int i = 0; i < NP; i++) begin
      if (i == nxt && cnt < CAP) begin
        if (is32[i] && i == NP - 1) begin
          d_strad = 1'b1;
          nxt     = NP;
        end else begin
          d_vld[cnt]            = 1'b1;
          d_len[cnt]            = is32[i];
          d_long[cnt]           = islong[i];
          d_idx[cnt*IW +: IW]   = IW'(i);
          cnt                   = cnt + 1;
          nxt                   = i + (is32[i] ? 2 : 1);
        end
      end
    end
    d_cnt  = CW'(cnt);
    d_used = UW'(nxt - base);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      head_q      <= '0;
      o_valid     <= 1'b0;
      o_slot_vld  <= '0;
      o_slot_idx  <= '0;
      o_slot_len  <= '0;
      o_slot_long <= '0;
      o_head_used <= 1'b0;
      o_head      <= '0;
      o_count     <= '0;
      o_used      <= '0;
    end else if (flush) begin
      pend_q      <= 1'b0;
      head_q      <= '0;
      o_valid     <= 1'b0;
      o_slot_vld  <= '0;
      o_count     <= '0;
      o_used      <= '0;
      o_head_used <= 1'b0;
    end else if (ready) begin
      o_valid <= win_valid;
      if (win_valid) begin
        o_slot_vld  <= d_vld;
        o_slot_idx  <= d_idx;
        o_slot_len  <= d_len;
        o_slot_long <= d_long;
        o_count     <= d_cnt;
        o_used      <= d_used;
        o_head_used <= pend_q;
        o_head      <= pend_q ? head_q : '0;
        pend_q      <= d_strad;
        if (d_strad) head_q <= window[(NP-1)*PW +: PW];
      end else begin
        o_slot_vld  <= '0;
        o_count     <= '0;
        o_used      <= '0;
        o_head_used <= 1'b0;
      end
    end
  end

endmodule

module insn_boundary_chk #(
  parameter int NP  = 8,
  parameter int CAP = 6,
  parameter int IW  = 3,
  parameter int CW  = 3,
  parameter int UW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              ready,
  input logic              win_valid,
  input logic              o_valid,
  input logic [CAP-1:0]    o_slot_vld,
  input logic [CAP*IW-1:0] o_slot_idx,
  input logic [CAP-1:0]    o_slot_len,
  input logic [CAP-1:0]    o_slot_long,
  input logic              o_head_used,
  input logic [CW-1:0]     o_count,
  input logic [UW-1:0]     o_used
);
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n) int'(o_count) <= CAP); // R4
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $countones(o_slot_vld) == int'(o_count)); // R4
  AST_LONG_IS_WIDE: assert property (@(posedge clk) disable iff (!rst_n) (o_slot_long & ~o_slot_len) == '0); // R2
  AST_USED_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(o_used) <= NP); // R3
  AST_HEAD_SLOT0: assert property (@(posedge clk) disable iff (!rst_n) o_head_used |-> (o_slot_vld[0] && o_slot_len[0] && o_slot_idx[IW-1:0] == '0)); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ready && !flush) |=> ($stable(o_slot_vld) && $stable(o_count) && $stable(o_used) && $stable(o_head_used) && $stable(o_valid))); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (o_count == '0 && !o_head_used && !o_valid)); // R8
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (ready && !flush && !win_valid) |=> (!o_valid && o_count == '0)); // R9
endmodule

bind insn_boundary_decoder insn_boundary_chk #(.NP(NP), .CAP(CAP), .IW(IW), .CW(CW), .UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ready(ready), .win_valid(win_valid),
  .o_valid(o_valid), .o_slot_vld(o_slot_vld), .o_slot_idx(o_slot_idx),
  .o_slot_len(o_slot_len), .o_slot_long(o_slot_long), .o_head_used(o_head_used),
  .o_count(o_count), .o_used(o_used)
);

// File: tb/sim_insn_boundary_decoder.sv
`timescale 1ns/1ps
module sim_insn_boundary_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, flush, ready, win_valid;
  logic [2:0]   start_off;
  logic [127:0] window;
  logic         o_valid, o_head_used;
  logic [5:0]   o_slot_vld, o_slot_len, o_slot_long;
  logic [17:0]  o_slot_idx;
  logic [15:0]  o_head;
  logic [2:0]   o_count;
  logic [3:0]   o_used;

  insn_boundary_decoder u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ready(ready), .win_valid(win_valid),
    .start_off(start_off), .window(window), .o_valid(o_valid), .o_slot_vld(o_slot_vld),
    .o_slot_idx(o_slot_idx), .o_slot_len(o_slot_len), .o_slot_long(o_slot_long),
    .o_head_used(o_head_used), .o_head(o_head), .o_count(o_count), .o_used(o_used)
  );

  int total = 0, bad = 0;
  bit m_pend = 0;
  logic [15:0] m_head = '0;
  int e_cnt, e_used;
  int e_idx[6];
  bit e_len[6], e_long[6];
  bit e_hu, e_strad;
  logic [15:0] e_head;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [15:0] mkpar(int i, int m, int salt);
    logic [15:0] p;
    p = {5'(i + salt), 6'(m), 5'b0};
    if (m[i]) begin
      if ((i + salt) % 4 == 0) p[4:0] = 5'b11111;
      else p[4:0] = {3'((i + salt) % 7), 2'b11};
    end else p[1:0] = 2'((i + salt) % 3);
    return p;
  endfunction

  task automatic build(int m, int salt);
    for (int i = 0; i < 8; i++) window[i*16 +: 16] = mkpar(i, m, salt);
  endtask

  task automatic predict(int off);
    int pos, n, base;
    logic [15:0] p;
    for (int s = 0; s < 6; s++) begin e_idx[s] = 0; e_len[s] = 0; e_long[s] = 0; end
    e_strad = 0; e_hu = m_pend; e_head = m_pend ? m_head : 16'h0;
    n = 0; base = m_pend ? 0 : off; pos = base;
    if (m_pend) begin
      e_len[0] = 1; e_long[0] = m_head[4:0] == 5'b11111; e_idx[0] = 0; n = 1; pos = 1;
    end
    while (pos < 8 && n < 6) begin
      p = window[pos*16 +: 16];
      if (p[1:0] == 2'b11 && pos == 7) begin e_strad = 1; pos = 8; end
      else begin
        e_idx[n] = pos; e_len[n] = p[1:0] == 2'b11; e_long[n] = p[4:0] == 5'b11111;
        n++; pos += (p[1:0] == 2'b11) ? 2 : 1;
      end
    end
    e_cnt = n; e_used = pos - base;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic check_all;
    chk(o_valid == 1'b1, "R3 valid", int'(o_valid), 1);
    chk(int'(o_count) == e_cnt, "R4 count", int'(o_count), e_cnt);
    chk(int'(o_used) == e_used, "R3 used", int'(o_used), e_used);
    chk(o_head_used == e_hu, "R6 head_used", int'(o_head_used), int'(e_hu));
    if (e_hu) chk(o_head == e_head, "R6 head", int'(o_head), int'(e_head));
    for (int s = 0; s < 6; s++) begin
      chk(o_slot_vld[s] == (s < e_cnt), "R4 slot_vld", int'(o_slot_vld[s]), int'(s < e_cnt));
      if (s < e_cnt) begin
        chk(int'(o_slot_idx[s*3 +: 3]) == e_idx[s], "R3 slot_idx", int'(o_slot_idx[s*3 +: 3]), e_idx[s]);
        chk(o_slot_len[s] == e_len[s], "R1 slot_len", int'(o_slot_len[s]), int'(e_len[s]));
        chk(o_slot_long[s] == e_long[s], "R2 slot_long", int'(o_slot_long[s]), int'(e_long[s]));
      end
    end
  endtask

  task automatic run_win(int m, int off, int salt);
    build(m, salt); start_off = 3'(off); win_valid = 1; ready = 1; flush = 0;
    predict(off);
    step;
    check_all;
    if (e_strad) m_head = window[7*16 +: 16];
    m_pend = e_strad;
  endtask

  task automatic do_flush;
    flush = 1; step; flush = 0; m_pend = 0;
  endtask

  initial begin
    #900000;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, u0v;
    rst_n = 0; flush = 0; ready = 0; win_valid = 0; start_off = 0; window = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    chk(o_valid == 0 && o_count == 0 && o_slot_vld == 0, "R10 reset outputs", int'(o_count), 0);
    chk(o_head_used == 0, "R10 reset head", int'(o_head_used), 0);

    // R4 all-16 capped
    run_win(0, 0, 1);
    chk(o_count == 3'd6 && o_used == 4'd6, "R4 all16 cap", int'(o_used), 6);
    // R5 all-32
    run_win(255, 0, 1);
    chk(o_count == 3'd4 && o_used == 4'd8, "R5 all32", int'(o_used), 8);
    chk(o_slot_idx == {3'd0, 3'd0, 3'd6, 3'd4, 3'd2, 3'd0}, "R5 all32 idx", int'(o_slot_idx), 18'o006420);

    // R6 directed straddle: offset 2, 16-bit 2..6, 32-bit at 7
    run_win(8'h80, 2, 0);
    chk(o_count == 3'd5 && o_used == 4'd6, "R6 straddle hold", int'(o_used), 6);
    // R7 stall: outputs and held half unchanged
    c0 = int'(o_count); u0v = int'(o_used);
    build(8'hFF, 3); start_off = 5; ready = 0; win_valid = 1;
    step; step;
    chk(int'(o_count) == c0 && int'(o_used) == u0v && !o_head_used, "R7 stall hold", int'(o_count), c0);
    // R9 idle cycle keeps held half
    ready = 1; win_valid = 0; step;
    chk(o_valid == 0 && o_count == 0, "R9 idle empty", int'(o_count), 0);
    run_win(0, 4, 2);
    chk(o_head_used == 1 && o_slot_idx[2:0] == 0, "R6 joined slot0", int'(o_head_used), 1);

    // R8 flush drops held half
    run_win(8'h80, 2, 0);
    flush = 1; ready = 0; step; flush = 0; m_pend = 0;
    chk(o_count == 0 && o_head_used == 0 && o_valid == 0, "R8 flush clear", int'(o_count), 0);
    run_win(0, 0, 2);
    chk(o_head_used == 0, "R8 no head after flush", int'(o_head_used), 0);

    // sweep every offset and length mask
    for (int off = 0; off < 8; off++)
      for (int m = 0; m < 256; m++) run_win(m, off, m + off);
    do_flush;
    for (int m = 0; m < 256; m++) run_win(m ^ 8'h5A, (m * 3) % 8, m);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule